// File: doc/BRIEF.md
# Fetch Group Alignment Rotator

This block sits between an instruction-cache row read and the decode stage. It receives one full cache row, which is wider than the fetch group, together with a predecode bit for each instruction and the fetch PC. It delivers up to `SLOTS` instructions, packed so that the instruction at the PC sits in output slot 0. The default is 4 slots taken from an 8-instruction row.

Only one row can be read per cycle, so a group never crosses into the next row. The group ends early at the end of the row. It also ends right after the first instruction whose predecode bit marks it as a branch. The block reports a per-slot valid mask, the number of delivered instructions and the sequential next PC. PCs are counted in instruction units, and the low `log2(ROW_W)` bits select the start slot within the row. `ROW_W` must be a power of two.

The result is registered: outputs appear one clock after the inputs are presented. A stall input freezes the registered outputs.

Top module: `fetch_align_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, up to the first capture, `vld_o`, `cnt_o`, `next_pc_o` and `grp_o` are all zero.
- R2: For a delivered slot i, `grp_o` slot i (bits i*INST_W upward) holds row word (off+i), where off = `pc_i[OFF_W-1:0]` and row word k occupies `row_i[k*INST_W +: INST_W]`.
- R3: With no predecode bit set among the words it would take, and off <= ROW_W-SLOTS, the group holds all SLOTS instructions.
- R4: The group never goes past the last word of the row: `cnt_o` <= ROW_W-off. With off = 5, 6 or 7 in the default configuration and no branch, 3, 2 or 1 instructions are delivered.
- R5: A group ends directly after the first delivered word whose bit in `brk_i` (bit k for row word k) is 1. If that word is at the PC, exactly one instruction is delivered.
- R6: `vld_o` is a run of ones starting at bit 0, and `cnt_o` equals the number of ones in it.
- R7: `next_pc_o` equals the captured `pc_i` plus `cnt_o`, modulo 2^PC_W.
- R8: Slots whose `vld_o` bit is 0 carry all-zero data in `grp_o`.
- R9: When `req_i` is low on a capture, the outputs show `vld_o`=0, `cnt_o`=0 and `next_pc_o` equal to the captured `pc_i`.
- R10: While `stall_i` is high, all outputs keep their values and changes on the other inputs have no effect on them.
- R11: On a request, `vld_o` bit 0 is always 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A row and PC are presented this cycle |
| stall_i | input | 1 | Hold the registered outputs |
| pc_i | input | PC_W | Fetch PC in instruction units |
| row_i | input | ROW_W*INST_W | Cache row, word k at bits k*INST_W |
| brk_i | input | ROW_W | Predecode branch flag per row word |
| grp_o | output | SLOTS*INST_W | Aligned fetch group, slot 0 first |
| vld_o | output | SLOTS | Per-slot valid mask |
| cnt_o | output | CNT_W | Number of delivered instructions |
| next_pc_o | output | PC_W | Sequential next fetch PC |

## Verification
Every start offset in the row is combined with every one of the 256 predecode masks. This separates the row-end cut from the branch cut and shows which of the two wins when both apply. Row contents change from vector to vector, so a rotation by the wrong amount or a stale word shows up as a data mismatch. Extra patterns cover the things the sweep does not reach. A PC near the top of its range checks that the next-PC sum wraps. Requests are dropped to check the idle output. Inputs are changed under stall to check that the outputs hold.

// File: rtl/fetch_align_pkg.sv
package fetch_align_pkg;
  localparam int unsigned FA_SLOTS  = 4;
  localparam int unsigned FA_ROW_W  = 8;
  localparam int unsigned FA_INST_W = 32;
  localparam int unsigned FA_PC_W   = 32;
endpackage

// File: rtl/fa_rotator.sv
// Rotates N words of W bits so that word sh_i lands at position 0.
module fa_rotator #(
  parameter int unsigned N    = 8,
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(N)
) (
  input  logic [N*W-1:0]  data_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [N*W-1:0]  data_o
);
  logic [N*W-1:0] stg [0:SH_W];

  assign stg[0] = data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned K = (1 << s) * W;
    assign stg[s+1] = sh_i[s] ? {stg[s][K-1:0], stg[s][N*W-1:K]} : stg[s];
  end

  assign data_o = stg[SH_W];
endmodule

// File: rtl/fa_mask.sv
// Builds the delivered-slot mask from row-end limit and branch cut.
module fa_mask #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned ROW_W = 8,
  parameter int unsigned OFF_W = $clog2(ROW_W)
) (
  input  logic             req_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SLOTS-1:0] brk_rot_i,
  output logic [SLOTS-1:0] vld_o
);
  localparam int unsigned SUM_W = OFF_W + 1;

  logic [SLOTS-1:0] in_row;
  logic [SLOTS-1:0] keep;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign in_row[i] = ({1'b0, off_i} + SUM_W'(i)) < SUM_W'(ROW_W);
    if (i == 0) begin : g_head
      assign keep[i] = req_i & in_row[i];
    end else begin : g_tail
      assign keep[i] = keep[i-1] & in_row[i] & ~brk_rot_i[i-1];
    end
  end

  assign vld_o = keep;
endmodule

// File: rtl/fa_count.sv
module fa_count #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] vld_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PC_W-1:0]  next_pc_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      cnt_o = cnt_o + CNT_W'(vld_i[i]);
    end
  end

  assign next_pc_o = pc_i + PC_W'(cnt_o);
endmodule

// File: rtl/fetch_align_top.sv
module fetch_align_top
  import fetch_align_pkg::*;
#(
  parameter int unsigned SLOTS  = FA_SLOTS,
  parameter int unsigned ROW_W  = FA_ROW_W,
  parameter int unsigned INST_W = FA_INST_W,
  parameter int unsigned PC_W   = FA_PC_W,
  localparam int unsigned OFF_W = $clog2(ROW_W),
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    stall_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic [ROW_W*INST_W-1:0] row_i,
  input  logic [ROW_W-1:0]        brk_i,
  output logic [SLOTS*INST_W-1:0] grp_o,
  output logic [SLOTS-1:0]        vld_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [PC_W-1:0]         next_pc_o
);
  logic [OFF_W-1:0]        off;
  logic [ROW_W*INST_W-1:0] row_rot;
  logic [ROW_W-1:0]        brk_rot;
  logic [SLOTS-1:0]        vld_d;
  logic [CNT_W-1:0]        cnt_d;
  logic [PC_W-1:0]         npc_d;
  logic [SLOTS*INST_W-1:0] grp_d;

  assign off = pc_i[OFF_W-1:0];

  fa_rotator #(.N(ROW_W), .W(INST_W), .SH_W(OFF_W)) u_rot_data (
    .data_i (row_i),
    .sh_i   (off),
    .data_o (row_rot)
  );

  fa_rotator #(.N(ROW_W), .W(1), .SH_W(OFF_W)) u_rot_brk (
    .data_i (brk_i),
    .sh_i   (off),
    .data_o (brk_rot)
  );

  fa_mask #(.SLOTS(SLOTS), .ROW_W(ROW_W), .OFF_W(OFF_W)) u_mask (
    .req_i     (req_i),
    .off_i     (off),
    .brk_rot_i (brk_rot[SLOTS-1:0]),
    .vld_o     (vld_d)
  );

  fa_count #(.SLOTS(SLOTS), .PC_W(PC_W), .CNT_W(CNT_W)) u_cnt (
    .vld_i     (vld_d),
    .pc_i      (pc_i),
    .cnt_o     (cnt_d),
    .next_pc_o (npc_d)
  );

  // undelivered slots are zeroed so downstream never sees stale words
  for (genvar i = 0; i < SLOTS; i++) begin : g_gate
    assign grp_d[i*INST_W +: INST_W] = vld_d[i] ? row_rot[i*INST_W +: INST_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_o     <= '0;
      vld_o     <= '0;
      cnt_o     <= '0;
      next_pc_o <= '0;
    end else if (!stall_i) begin
      grp_o     <= grp_d;
      vld_o     <= vld_d;
      cnt_o     <= cnt_d;
      next_pc_o <= npc_d;
    end
  end
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned INST_W = 32,
  parameter int unsigned PC_W   = 32,
  localparam int unsigned OFF_W = $clog2(ROW_W),
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    stall_i,
  input logic [PC_W-1:0]         pc_i,
  input logic [ROW_W*INST_W-1:0] row_i,
  input logic [ROW_W-1:0]        brk_i,
  input logic [SLOTS*INST_W-1:0] grp_o,
  input logic [SLOTS-1:0]        vld_o,
  input logic [CNT_W-1:0]        cnt_o,
  input logic [PC_W-1:0]         next_pc_o
);
  logic [OFF_W-1:0]  off;
  logic [INST_W-1:0] head_w;
  logic [OFF_W:0]    avail;

  assign off    = pc_i[OFF_W-1:0];
  assign head_w = row_i[off*INST_W +: INST_W];
  assign avail  = (OFF_W+1)'(ROW_W) - {1'b0, off};

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(grp_o) && $stable(vld_o) && $stable(cnt_o) && $stable(next_pc_o)));

  assert_prefix_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vld_o & (vld_o + SLOTS'(1))) == '0) && (cnt_o == CNT_W'($countones(vld_o))));

  assert_next_pc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> next_pc_o == $past(pc_i) + PC_W'(cnt_o));

  assert_head_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !stall_i) |=> grp_o[INST_W-1:0] == $past(head_w));

  assert_row_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !stall_i) |=> (OFF_W+1)'(cnt_o) <= $past(avail));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !stall_i) |=> (vld_o == '0));

  assert_head_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !stall_i) |=> vld_o[0]);
endmodule

bind fetch_align_top fa_checker #(
  .SLOTS(SLOTS), .ROW_W(ROW_W), .INST_W(INST_W), .PC_W(PC_W)
) u_fa_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .stall_i   (stall_i),
  .pc_i      (pc_i),
  .row_i     (row_i),
  .brk_i     (brk_i),
  .grp_o     (grp_o),
  .vld_o     (vld_o),
  .cnt_o     (cnt_o),
  .next_pc_o (next_pc_o)
);

// File: tb/tb_fetch_align_top.sv
module tb_fetch_align_top;
  localparam int SLOTS  = 4;
  localparam int ROW_W  = 8;
  localparam int INST_W = 32;
  localparam int PC_W   = 32;
  localparam int CNT_W  = 3;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    req_i = 1'b0;
  logic                    stall_i = 1'b0;
  logic [PC_W-1:0]         pc_i = '0;
  logic [ROW_W*INST_W-1:0] row_i = '0;
  logic [ROW_W-1:0]        brk_i = '0;
  logic [SLOTS*INST_W-1:0] grp_o;
  logic [SLOTS-1:0]        vld_o;
  logic [CNT_W-1:0]        cnt_o;
  logic [PC_W-1:0]         next_pc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz
  always @(posedge clk_i) cycles <= cycles + 1;

  fetch_align_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .stall_i(stall_i),
    .pc_i(pc_i), .row_i(row_i), .brk_i(brk_i), .grp_o(grp_o),
    .vld_o(vld_o), .cnt_o(cnt_o), .next_pc_o(next_pc_o)
  );

  function automatic logic [INST_W-1:0] word_of(int seed, int k);
    return 32'hC0DE_0000 + INST_W'(seed * 16 + k + 1);
  endfunction

  task automatic chk(string tag, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill_row(int seed);
    for (int k = 0; k < ROW_W; k++) row_i[k*INST_W +: INST_W] = word_of(seed, k);
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // checks outputs of a request captured with pc/brk/seed
  task automatic expect_req(logic [PC_W-1:0] pc, logic [ROW_W-1:0] brk, int seed, string tag);
    int off = int'(pc[2:0]);
    int n = 0;
    logic [SLOTS-1:0] m;
    for (int i = 0; i < SLOTS; i++) begin
      if (off + i >= ROW_W) break;
      n++;
      if (brk[off + i]) break;
    end
    m = SLOTS'((1 << n) - 1);
    chk({tag, " cnt"}, PC_W'(cnt_o), PC_W'(n));
    chk("R6 vld", PC_W'(vld_o), PC_W'(m));
    chk("R7 next_pc", next_pc_o, pc + PC_W'(n));
    for (int i = 0; i < SLOTS; i++) begin
      if (i < n) chk("R2 slot data", grp_o[i*INST_W +: INST_W], word_of(seed, off + i));
      else       chk("R8 empty slot", grp_o[i*INST_W +: INST_W], '0);
    end
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    logic [SLOTS*INST_W-1:0] g_hold;
    logic [PC_W-1:0]         p_hold;
    repeat (3) @(negedge clk_i);
    chk("R1 reset vld", PC_W'(vld_o), '0);
    chk("R1 reset cnt", PC_W'(cnt_o), '0);
    chk("R1 reset next_pc", next_pc_o, '0);
    chk("R1 reset grp", PC_W'(|grp_o), '0);
    rst_ni = 1'b1;
    tick();
    chk("R1 after release", PC_W'(vld_o), '0);

    // exhaustive sweep: every offset x every predecode mask
    seed = 0;
    req_i = 1'b1;
    for (int off = 0; off < ROW_W; off++) begin
      for (int b = 0; b < (1 << ROW_W); b++) begin
        logic [PC_W-1:0] pc;
        string tag;
        seed++;
        pc = PC_W'(32'h0001_0000 + seed * 8 + off);
        pc_i = pc;
        brk_i = ROW_W'(b);
        fill_row(seed);
        tick();
        if (b == 0 && off <= ROW_W - SLOTS) tag = "R3";
        else if (b == 0) tag = "R4";
        else tag = "R5";
        expect_req(pc, ROW_W'(b), seed, tag);
        if (b == 0 && off > ROW_W - SLOTS) chk("R4 row end", PC_W'(cnt_o), PC_W'(ROW_W - off));
        if (brk_i[off]) chk("R5 branch at head", PC_W'(cnt_o), 1);
        chk("R11 head valid", PC_W'(vld_o[0]), 1);
      end
    end

    // next-pc wrap
    seed++;
    pc_i = 32'hFFFF_FFFE;
    brk_i = '0;
    fill_row(seed);
    tick();
    expect_req(32'hFFFF_FFFE, '0, seed, "R4");
    chk("R7 wrap", next_pc_o, 32'h0);

    // idle request
    req_i = 1'b0;
    pc_i = 32'h0000_1235;
    brk_i = 8'hFF;
    tick();
    chk("R9 idle vld", PC_W'(vld_o), '0);
    chk("R9 idle cnt", PC_W'(cnt_o), '0);
    chk("R9 idle next_pc", next_pc_o, 32'h0000_1235);
    chk("R8 idle grp", PC_W'(|grp_o), '0);

    // stall hold
    req_i = 1'b1;
    seed++;
    pc_i = 32'h0000_2002;
    brk_i = 8'b0001_0000;
    fill_row(seed);
    tick();
    expect_req(32'h0000_2002, 8'b0001_0000, seed, "R5");
    g_hold = grp_o;
    p_hold = next_pc_o;
    stall_i = 1'b1;
    for (int r = 0; r < 4; r++) begin
      pc_i = PC_W'(32'h0000_3000 + r * 3);
      brk_i = ROW_W'(r * 37);
      req_i = r[0];
      fill_row(seed + 100 + r);
      tick();
      chk("R10 hold grp", PC_W'(grp_o == g_hold), 1);
      chk("R10 hold next_pc", next_pc_o, p_hold);
      chk("R10 hold cnt", PC_W'(cnt_o), 3);
    end
    stall_i = 1'b0;
    req_i = 1'b1;
    seed++;
    pc_i = 32'h0000_4004;
    brk_i = '0;
    fill_row(seed);
    tick();
    expect_req(32'h0000_4004, '0, seed, "R10 release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule